// File: doc/BRIEF.md
# Banked Program Address Sequencer

This block produces the instruction-fetch address for a small 4-bit controller. It keeps a 13-bit program counter (PC) and a 2-bit bank register. It turns the PC into a 14-bit address into a 16K-byte program ROM, which is organised as four 4K banks. Logical addresses below 1000h always reach bank 0. The logical range 1000h–1FFFh is a window, and the bank register chooses which physical bank that window shows. Each cycle the instruction decoder presents one command. The command can hold the PC, step it, load it, call through one of two restricted call forms, or return. An interrupt-request vector overrides the command and sends the PC to a fixed entry address.

Calls and interrupt entries save the address that follows the current PC on a 13-entry hardware return stack. Returns restore the most recent saved address. Two sticky flags record a push that found the stack full and a pop that found it empty. Only reset clears these flags. No data stream passes through the block, so it has no valid/ready handshake and nothing can stall it. Every input is sampled on each rising clock edge.

Top module: `prog_addr_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, PC = 0000h and bank register = 00, so `rom_addr` = 0000h, and `stk_ovf` and `stk_unf` are 0.
- R2: When PC[12] = 0, `rom_addr` = {2'b00, PC[11:0]}, whatever the bank register holds.
- R3: When PC[12] = 1, `rom_addr` = {bank, PC[11:0]}, where bank register code 00 or 11 gives bank 1, code 01 gives bank 2 and code 10 gives bank 3.
- R4: When `bank_we` = 1, the bank register loads `bank_wdata` at the clock edge. `rom_addr` changes only from the next cycle on, and stays at its old value during the cycle of the write.
- R5: Command 1 (step) sets PC to PC+1 modulo 2^13, so 1FFFh wraps to 0000h.
- R6: Command 2 (branch) loads all 13 bits of `br_target` into PC.
- R7: Command 3 (short call) pushes PC+1 and loads PC = 000Eh + 8·`scall_idx`, which gives 000Eh through 0086h.
- R8: Command 4 (long call) pushes PC+1 and loads PC = {2'b00, `br_target[10:0]`}. `br_target[12:11]` is ignored.
- R9: Command 5 (return) loads PC from the most recently pushed address that has not yet been popped, in last-in first-out order.
- R10: When any `irq_req` bit is set, the command is ignored. The block pushes PC+1 and loads PC = 2·(i+1), where i is the lowest set bit index. Bit 0 gives 0002h and bit 5 gives 000Ch.
- R11: A push with 13 entries already held sets `stk_ovf`, which stays set until reset. The push is discarded, the stored entries are kept, and the PC still moves to the call or vector target.
- R12: A return with the stack empty sets `stk_unf`, which stays set until reset, and leaves PC unchanged.
- R13: Command 0 (hold), and the unused codes 6 and 7, leave PC unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | PC update command: 0 hold, 1 step, 2 branch, 3 short call, 4 long call, 5 return |
| br_target | input | 13 | Branch target; bits 10:0 are the long-call target |
| scall_idx | input | 4 | Short-call entry slot number |
| irq_req | input | 6 | Interrupt requests, bit 0 has the highest priority |
| bank_we | input | 1 | Bank register write enable |
| bank_wdata | input | 2 | Bank register write value |
| rom_addr | output | 14 | Physical program ROM fetch address |
| stk_ovf | output | 1 | Sticky return-stack overflow flag |
| stk_unf | output | 1 | Sticky return-stack underflow flag |

## Verification
The bench builds the block with its default parameters: a 13-bit PC, a 2-bit bank register, a 13-entry stack and six interrupt inputs. With these values, a run of 14 long calls fills the stack and then overflows it, so every stored entry is read back before the underflow. The 4-bit short-call index reaches both end slots, 000Eh and 0086h. All four bank codes are exercised against PCs on both sides of the window boundary, including the wrap from 1FFFh to 0000h.

// File: rtl/pas_pkg.sv
package pas_pkg;

  typedef enum logic [2:0] {
    PAS_HOLD  = 3'd0,
    PAS_STEP  = 3'd1,
    PAS_JUMP  = 3'd2,
    PAS_SCALL = 3'd3,
    PAS_LCALL = 3'd4,
    PAS_RET   = 3'd5
  } pas_cmd_e;

endpackage

// File: rtl/pas_bank_map.sv
module pas_bank_map #(
  parameter int CODE_W = 2,
  parameter int PBANK_W = 2
) (
  input  logic               in_window,
  input  logic [CODE_W-1:0]  bank_code,
  output logic [PBANK_W-1:0] phys_bank
);

  logic [PBANK_W-1:0] mapped;

  // Codes 00 and 11 share bank 1; 01 -> bank 2; 10 -> bank 3.
  always_comb begin
    unique case (bank_code[1:0])
      2'b01:   mapped = PBANK_W'(2);
      2'b10:   mapped = PBANK_W'(3);
      default: mapped = PBANK_W'(1);
    endcase
  end

  assign phys_bank = in_window ? mapped : '0;

endmodule

// File: rtl/pas_irq_prio.sv
module pas_irq_prio #(
  parameter int N_IRQ = 6,
  parameter int AW = 13
) (
  input  logic [N_IRQ-1:0] req,
  output logic             any,
  output logic [AW-1:0]    vec_addr
);

  // Scan from the top so the lowest set index is written last and wins.
  always_comb begin
    vec_addr = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (req[i]) vec_addr = AW'(2 * (i + 1));
    end
  end

  assign any = |req;

endmodule

// File: rtl/pas_ret_stack.sv
module pas_ret_stack #(
  parameter int W = 13,
  parameter int DEPTH = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);

  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] top_i;

  assign full  = (sp_q == SP_W'(DEPTH));
  assign empty = (sp_q == '0);
  assign top_i = sp_q - 1'b1;
  assign top   = empty ? '0 : mem[top_i[IDX_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (push && !full) begin
      sp_q <= sp_q + 1'b1;
    end else if (pop && !empty) begin
      sp_q <= sp_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[sp_q[IDX_W-1:0]] <= wdata;
  end

endmodule

// File: rtl/prog_addr_seq.sv
module prog_addr_seq
  import pas_pkg::*;
#(
  parameter int PC_W       = 13,
  parameter int BANK_W     = 2,
  parameter int STK_DEPTH  = 13,
  parameter int N_IRQ      = 6,
  parameter int SIDX_W     = 4,
  parameter int SCALL_BASE = 14,
  parameter int SCALL_STEP = 8,
  parameter int LCALL_W    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd,
  input  logic [PC_W-1:0]   br_target,
  input  logic [SIDX_W-1:0] scall_idx,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_wdata,
  output logic [PC_W:0]     rom_addr,
  output logic              stk_ovf,
  output logic              stk_unf
);

  localparam int OFS_W   = PC_W - 1;
  localparam int PBANK_W = 2;

  logic [PC_W-1:0]    pc_q, pc_d, pc_inc, stk_top, irq_vec;
  logic [BANK_W-1:0]  bank_q;
  logic [PBANK_W-1:0] phys_bank;
  logic               push, pop, stk_full, stk_empty, irq_any;
  logic               ovf_set, unf_set;
  pas_cmd_e           cmd_e;

  assign cmd_e  = pas_cmd_e'(cmd);
  assign pc_inc = pc_q + 1'b1;

  pas_irq_prio #(.N_IRQ(N_IRQ), .AW(PC_W)) u_prio (
    .req      (irq_req),
    .any      (irq_any),
    .vec_addr (irq_vec)
  );

  pas_ret_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .wdata (pc_inc),
    .top   (stk_top),
    .full  (stk_full),
    .empty (stk_empty)
  );

  pas_bank_map #(.CODE_W(BANK_W), .PBANK_W(PBANK_W)) u_map (
    .in_window (pc_q[PC_W-1]),
    .bank_code (bank_q),
    .phys_bank (phys_bank)
  );

  always_comb begin
    pc_d    = pc_q;
    push    = 1'b0;
    pop     = 1'b0;
    unf_set = 1'b0;
    if (irq_any) begin
      pc_d = irq_vec;
      push = 1'b1;
    end else begin
      unique case (cmd_e)
        PAS_STEP:  pc_d = pc_inc;
        PAS_JUMP:  pc_d = br_target;
        PAS_SCALL: begin
          pc_d = PC_W'(SCALL_BASE) + PC_W'(SCALL_STEP) * PC_W'(scall_idx);
          push = 1'b1;
        end
        PAS_LCALL: begin
          pc_d = PC_W'(br_target[LCALL_W-1:0]);
          push = 1'b1;
        end
        PAS_RET: begin
          if (stk_empty) begin
            unf_set = 1'b1;
          end else begin
            pc_d = stk_top;
            pop  = 1'b1;
          end
        end
        default: pc_d = pc_q;
      endcase
    end
  end

  assign ovf_set = push & stk_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      bank_q  <= '0;
      stk_ovf <= 1'b0;
      stk_unf <= 1'b0;
    end else begin
      pc_q <= pc_d;
      if (bank_we) bank_q <= bank_wdata;
      if (ovf_set) stk_ovf <= 1'b1;
      if (unf_set) stk_unf <= 1'b1;
    end
  end

  assign rom_addr = {phys_bank, pc_q[OFS_W-1:0]};

endmodule

// File: rtl/pas_checker.sv
module pas_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  cmd,
  input logic [5:0]  irq_req,
  input logic [12:0] pc_q,
  input logic [13:0] rom_addr,
  input logic        stk_ovf,
  input logic        stk_unf,
  input logic        stk_empty
);

  assert_lowwin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_q[12] |-> rom_addr[13:12] == 2'b00);

  assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[12] |-> rom_addr[13:12] != 2'b00);

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1 && irq_req == '0) |=> pc_q == $past(pc_q) + 13'd1);

  assert_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req != '0) |=> (pc_q != '0 && pc_q <= 13'h00C && !pc_q[0]));

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |=> stk_ovf);

  assert_unf_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stk_unf |=> stk_unf);

  assert_unf_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd5 && irq_req == '0 && stk_empty) |=> ($stable(pc_q) && stk_unf));

  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd0 && irq_req == '0) |=> $stable(pc_q));

endmodule

bind prog_addr_seq pas_checker u_pas_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd       (cmd),
  .irq_req   (irq_req),
  .pc_q      (pc_q),
  .rom_addr  (rom_addr),
  .stk_ovf   (stk_ovf),
  .stk_unf   (stk_unf),
  .stk_empty (stk_empty)
);

// File: tb/test_prog_addr_seq.sv
module test_prog_addr_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = '0;
  logic [12:0] br_target = '0;
  logic [3:0]  scall_idx = '0;
  logic [5:0]  irq_req = '0;
  logic        bank_we = 1'b0;
  logic [1:0]  bank_wdata = '0;
  logic [13:0] rom_addr;
  logic        stk_ovf, stk_unf;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prog_addr_seq i_prog_addr_seq (
    .clk, .rst_n, .cmd, .br_target, .scall_idx, .irq_req,
    .bank_we, .bank_wdata, .rom_addr, .stk_ovf, .stk_unf
  );

  // {cmd[3], target[13], idx[4], irq[6], we, wdata[2], expected rom_addr[14]}
  localparam int NV = 21;
  localparam logic [42:0] VECS [NV] = '{
    {3'd1, 13'h0000, 4'd0,  6'h00, 1'b0, 2'd0, 14'h0001}, // R5 step
    {3'd1, 13'h0000, 4'd0,  6'h00, 1'b0, 2'd0, 14'h0002}, // R5
    {3'd2, 13'h1005, 4'd0,  6'h00, 1'b0, 2'd0, 14'h1005}, // R6 R3 code 00
    {3'd1, 13'h0000, 4'd0,  6'h00, 1'b1, 2'd1, 14'h2006}, // R4 R3 code 01
    {3'd0, 13'h0000, 4'd0,  6'h00, 1'b1, 2'd2, 14'h3006}, // R3 code 10, R13
    {3'd0, 13'h0000, 4'd0,  6'h00, 1'b1, 2'd3, 14'h1006}, // R3 code 11
    {3'd3, 13'h0000, 4'd3,  6'h00, 1'b0, 2'd0, 14'h0026}, // R7 slot 3
    {3'd4, 13'h1ABC, 4'd0,  6'h00, 1'b0, 2'd0, 14'h02BC}, // R8 high bits dropped
    {3'd5, 13'h0000, 4'd0,  6'h00, 1'b0, 2'd0, 14'h0027}, // R9
    {3'd5, 13'h0000, 4'd0,  6'h00, 1'b0, 2'd0, 14'h1007}, // R9
    {3'd1, 13'h0000, 4'd0,  6'h2C, 1'b0, 2'd0, 14'h0006}, // R10 lowest of 2,3,5
    {3'd2, 13'h0555, 4'd0,  6'h20, 1'b0, 2'd0, 14'h000C}, // R10 overrides branch
    {3'd5, 13'h0000, 4'd0,  6'h00, 1'b0, 2'd0, 14'h0007}, // R10 pushed PC+1
    {3'd5, 13'h0000, 4'd0,  6'h00, 1'b0, 2'd0, 14'h1008}, // R10
    {3'd3, 13'h0000, 4'd15, 6'h00, 1'b0, 2'd0, 14'h0086}, // R7 last slot
    {3'd5, 13'h0000, 4'd0,  6'h00, 1'b0, 2'd0, 14'h1009}, // R9
    {3'd2, 13'h1FFF, 4'd0,  6'h00, 1'b0, 2'd0, 14'h1FFF}, // R6
    {3'd1, 13'h0000, 4'd0,  6'h00, 1'b0, 2'd0, 14'h0000}, // R5 wrap
    {3'd7, 13'h0000, 4'd0,  6'h00, 1'b0, 2'd0, 14'h0000}, // R13 unused code
    {3'd0, 13'h0000, 4'd0,  6'h00, 1'b1, 2'd2, 14'h0000}, // R2 bank ignored low
    {3'd2, 13'h1800, 4'd0,  6'h00, 1'b0, 2'd0, 14'h3800}  // R3
  };

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic [12:0] t, input logic [3:0] i,
                      input logic [5:0] q, input logic we, input logic [1:0] wd);
    cmd = c; br_target = t; scall_idx = i; irq_req = q; bank_we = we; bank_wdata = wd;
    @(posedge clk);
    #1;
    bank_we = 1'b0; irq_req = '0; cmd = 3'd0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd = '0; irq_req = '0; bank_we = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #1;
    check("R1 in reset", rom_addr, 14'h0000);
    do_reset();
    check("R1 addr", rom_addr, 14'h0000);
    check("R1 ovf/unf", {12'h0, stk_ovf, stk_unf}, 14'h0000);

    for (int k = 0; k < NV; k++) begin
      step(VECS[k][42:40], VECS[k][39:27], VECS[k][26:23], VECS[k][22:17],
           VECS[k][16], VECS[k][15:14]);
      check($sformatf("vector %0d (see R-tag in table)", k), rom_addr, VECS[k][13:0]);
    end

    // R4: bank write does not alter the address of the cycle it occurs in
    do_reset();
    step(3'd2, 13'h1234, 4'd0, 6'h00, 1'b0, 2'd0);
    cmd = 3'd0; bank_wdata = 2'd2; bank_we = 1'b1;
    #2;
    check("R4 same cycle", rom_addr, 14'h1234);
    @(posedge clk);
    #1;
    bank_we = 1'b0;
    check("R4 next cycle", rom_addr, 14'h3234);

    // R10: each request alone, and all at once
    for (int b = 0; b < 6; b++) begin
      do_reset();
      step(3'd0, 13'h0, 4'd0, 6'(1 << b), 1'b0, 2'd0);
      check($sformatf("R10 bit %0d", b), rom_addr, 14'(2 * (b + 1)));
    end
    do_reset();
    step(3'd4, 13'h0100, 4'd0, 6'h3F, 1'b0, 2'd0);
    check("R10 all pending", rom_addr, 14'h0002);

    // R11/R12: fill, overflow, drain, underflow
    do_reset();
    for (int k = 1; k <= 13; k++) begin
      step(3'd4, 13'(k * 16), 4'd0, 6'h00, 1'b0, 2'd0);
    end
    check("R11 no flag at 13", {13'h0, stk_ovf}, 14'h0000);
    step(3'd4, 13'h0700, 4'd0, 6'h00, 1'b0, 2'd0);
    check("R11 flag", {13'h0, stk_ovf}, 14'h0001);
    check("R11 pc moves", rom_addr, 14'h0700);
    for (int k = 12; k >= 0; k--) begin
      step(3'd5, 13'h0, 4'd0, 6'h00, 1'b0, 2'd0);
      check($sformatf("R11 R9 pop %0d", k), rom_addr, 14'(k * 16 + 1));
    end
    check("R12 no flag yet", {13'h0, stk_unf}, 14'h0000);
    step(3'd5, 13'h0, 4'd0, 6'h00, 1'b0, 2'd0);
    check("R12 pc held", rom_addr, 14'h0001);
    check("R12 flag", {13'h0, stk_unf}, 14'h0001);
    step(3'd1, 13'h0, 4'd0, 6'h00, 1'b0, 2'd0);
    check("R11 R12 sticky", {12'h0, stk_ovf, stk_unf}, 14'h0003);
    do_reset();
    check("R1 flags cleared", {12'h0, stk_ovf, stk_unf}, 14'h0000);

    finish_run();
  end

endmodule